// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is a four-wire serial test port for a chip's boundary scan. A sixteen-state controller advances on each rising edge of the test clock according to the mode-select input. It routes one of four shift registers between the serial data input and output: a 3-bit instruction register, a 32-bit identification register, a single-bit bypass register, or a chain of boundary cells. Each boundary cell captures a parallel input and holds a parallel update output.

An instruction that selects the boundary chain can also take the functional outputs off the pins. While the high-impedance sampling instruction is active, the `force_hiz` output is high, and the boundary chain can still be captured, shifted and updated. The serial output and its enable change only on falling clock edges. Update actions take effect on falling edges as well. A synchronous active-low reset, or reaching the reset state with the mode-select input, brings the identification instruction back.

Top module: `scan_tap`

## Requirements
- R1: While `rst_n` is low at a rising `tck` edge, the controller enters its reset state. On the next falling edge the active instruction becomes IDCODE (code 001), `tdo_oe` goes low and `bnd_upd` goes to all zeros. A data scan that follows therefore reads the identification word.
- R2: Five consecutive rising edges with `tms` high put the controller in its reset state from any state, and the active instruction becomes IDCODE again. On the way out of Shift-DR this path passes through Update-DR, so the boundary update outputs still take the shifted contents.
- R3: The identification word is {revision[2:0] in bits 31:29, part number in bits 28:12, vendor code 00000110100 in bits 11:1, 1 in bit 0}. Bit 0 is shifted out first.
- R4: In Capture-IR the instruction shift register loads 001, which puts 01 in its two least significant bits. It shifts least significant bit first, and `tdi` enters at the most significant bit.
- R5: Codes 111, 011, 101 and 110 select the single-bit bypass register. It captures 0, so a data scan returns 0 followed by the input bits delayed by one position.
- R6: Code 010 (high-impedance sampling) selects the boundary chain. It drives `force_hiz` high from the falling edge in Update-IR until another instruction is updated or a reset occurs.
- R7: Codes 100 (sample/preload) and 000 (external test) also select the boundary chain. In Capture-DR every boundary cell loads `bnd_in`. Cell 0 is nearest `tdo`, and `tdi` enters cell BSR_LEN-1.
- R8: `bnd_upd` changes only on the falling edge in Update-DR while a boundary instruction is active. It holds its value through shifting and Exit1-DR, and through data scans of non-boundary registers.
- R9: Shifting a new instruction leaves the active instruction and `force_hiz` unchanged until the falling edge in Update-IR.
- R10: `tdo_oe` is high only in the half-cycle after a falling edge that occurs in Shift-IR or Shift-DR. It is low in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the rising edge of tck |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Drive enable for tdo |
| force_hiz | output | 1 | High while the functional outputs must float |
| bnd_in | input | BSR_LEN | Parallel values captured by the boundary cells |
| bnd_upd | output | BSR_LEN | Latched parallel outputs of the boundary cells |

## Verification
Two events can coincide on one mode-select escape: the boundary update and the reload of the identification instruction. To provoke this, a boundary scan under the high-impedance sampling instruction is stopped partway through Shift-DR by five `tms` highs. That path passes Update-DR and then the reset state. The bench checks that `bnd_upd` holds the partly shifted image, computed from the captured inputs and the bits shifted in, and that `force_hiz` has dropped. A second coincidence occurs in Capture-DR under sample/preload: the new `bnd_in` is captured while the old update outputs are held. The bench checks both halves at Exit1-DR and again after Update-DR.

// File: rtl/scan_tap_pkg.sv
// Shared types for the boundary scan test port: controller states,
// instruction codes and the decode from instruction to data path.
package scan_tap_pkg;

    // The sixteen controller states.
    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_t;

    localparam int IR_W = 3;
    typedef logic [IR_W-1:0] instr_t;

    localparam instr_t OP_EXTEST  = 3'b000;
    localparam instr_t OP_IDCODE  = 3'b001;
    localparam instr_t OP_SAMPLEZ = 3'b010;
    localparam instr_t OP_SAMPLE  = 3'b100;
    localparam instr_t OP_BYPASS  = 3'b111;

    // Data register that an instruction places between tdi and tdo.
    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_ID,
        PATH_BOUND
    } dr_path_t;

    // Reserved codes fall to bypass.
    function automatic dr_path_t decode_path(input instr_t op);
        dr_path_t p;
        case (op)
            OP_IDCODE:                         p = PATH_ID;
            OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE:  p = PATH_BOUND;
            default:                           p = PATH_BYPASS;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test port controller.
// Assumes: tms is stable around the rising edge of tck; rst_n is synchronous.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next state from the current state and tms.
    always_comb begin
        case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register, advanced on the rising edge.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction register: a shift stage that captures 0..01 and shifts
// LSB first, and an active stage loaded on the falling edge in Update-IR.
// Assumes: the active stage returns to IDCODE in the reset state.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_t state,
    input  logic       tdi,
    output instr_t     ir_sr,
    output instr_t     ir_q
);

    localparam instr_t CAP_PAT = instr_t'(2'b01);

    // Shift stage: capture the fixed pattern, then shift from tdi.
    always_ff @(posedge tck) begin
        if (!rst_n)                 ir_sr <= CAP_PAT;
        else if (state == ST_CAP_IR) ir_sr <= CAP_PAT;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction, changed only on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n || state == ST_RESET) ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR)     ir_q <= ir_sr;
    end

endmodule

// File: rtl/scan_tap_bcell.sv
// One boundary cell: a capture/shift stage on the rising edge and
// an update latch on the falling edge that holds the parallel output.
// Assumes: at most one of cap_en and sh_en is high.
module scan_tap_bcell (
    input  logic tck,
    input  logic rst_n,
    input  logic cap_en,
    input  logic sh_en,
    input  logic upd_en,
    input  logic par_in,
    input  logic ser_in,
    output logic ser_q,
    output logic par_q
);

    // Capture/shift stage.
    always_ff @(posedge tck) begin
        if (!rst_n)      ser_q <= 1'b0;
        else if (cap_en) ser_q <= par_in;
        else if (sh_en)  ser_q <= ser_in;
    end

    // Update latch, written only on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n)      par_q <= 1'b0;
        else if (upd_en) par_q <= ser_q;
    end

endmodule

// File: rtl/scan_tap_dr.sv
// Data registers: the identification word, the bypass bit and the boundary
// chain. Only the register on the selected path captures or shifts.
// Assumes: path is steady during a data scan (it changes only in Update-IR).
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN   = 16,
    parameter logic [2:0]  ID_REV    = 3'h0,
    parameter logic [16:0] ID_PART   = 17'h0B5C3,
    parameter logic [10:0] ID_VENDOR = 11'b00000110100
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_t         state,
    input  dr_path_t           path,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bnd_in,
    output logic [BSR_LEN-1:0] bnd_upd,
    output logic               byp_q,
    output logic               dr_out
);

    localparam int          ID_W    = 32;
    localparam logic [31:0] ID_WORD = {ID_REV, ID_PART, ID_VENDOR, 1'b1};

    logic [ID_W-1:0]    id_sr;
    logic [BSR_LEN-1:0] bsr_q;
    logic               cap_dr, sh_dr, bnd_cap, bnd_sh, bnd_upd_en;

    // State decodes shared by all data registers.
    always_comb begin
        cap_dr     = (state == ST_CAP_DR);
        sh_dr      = (state == ST_SH_DR);
        bnd_cap    = cap_dr && (path == PATH_BOUND);
        bnd_sh     = sh_dr  && (path == PATH_BOUND);
        bnd_upd_en = (state == ST_UPD_DR) && (path == PATH_BOUND);
    end

    // Identification register: capture the fixed word, shift LSB first.
    always_ff @(posedge tck) begin
        if (!rst_n)                          id_sr <= ID_WORD;
        else if (cap_dr && path == PATH_ID)  id_sr <= ID_WORD;
        else if (sh_dr && path == PATH_ID)   id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Bypass bit: capture zero, shift tdi.
    always_ff @(posedge tck) begin
        if (!rst_n)                              byp_q <= 1'b0;
        else if (cap_dr && path == PATH_BYPASS)  byp_q <= 1'b0;
        else if (sh_dr && path == PATH_BYPASS)   byp_q <= tdi;
    end

    // Boundary chain: cell 0 nearest tdo, tdi enters the top cell.
    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        logic ser_src;
        if (i == BSR_LEN - 1) begin : g_top
            assign ser_src = tdi;
        end else begin : g_mid
            assign ser_src = bsr_q[i+1];
        end
        scan_tap_bcell u_cell (
            .tck    (tck),
            .rst_n  (rst_n),
            .cap_en (bnd_cap),
            .sh_en  (bnd_sh),
            .upd_en (bnd_upd_en),
            .par_in (bnd_in[i]),
            .ser_in (ser_src),
            .ser_q  (bsr_q[i]),
            .par_q  (bnd_upd[i])
        );
    end

    // Serial output of the selected register.
    always_comb begin
        case (path)
            PATH_ID:    dr_out = id_sr[0];
            PATH_BOUND: dr_out = bsr_q[0];
            default:    dr_out = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_tap.sv
// Boundary scan test access port top: controller, instruction register,
// data registers and the falling-edge tdo stage.
// Assumes: one clock (tck); outputs that follow a falling edge are
// used by pads that sample them on the next rising edge.
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int          BSR_LEN   = 16,
    parameter logic [2:0]  ID_REV    = 3'h0,
    parameter logic [16:0] ID_PART   = 17'h0B5C3,
    parameter logic [10:0] ID_VENDOR = 11'b00000110100
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               force_hiz,
    input  logic [BSR_LEN-1:0] bnd_in,
    output logic [BSR_LEN-1:0] bnd_upd
);

    tap_state_t state;
    instr_t     ir_sr, ir_q;
    dr_path_t   path;
    logic       dr_out, byp_q;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (state)
    );

    scan_tap_ir u_ir (
        .tck   (tck),
        .rst_n (rst_n),
        .state (state),
        .tdi   (tdi),
        .ir_sr (ir_sr),
        .ir_q  (ir_q)
    );

    // Path and high-impedance request decoded from the active instruction.
    always_comb begin
        path      = decode_path(ir_q);
        force_hiz = (ir_q == OP_SAMPLEZ);
    end

    scan_tap_dr #(
        .BSR_LEN   (BSR_LEN),
        .ID_REV    (ID_REV),
        .ID_PART   (ID_PART),
        .ID_VENDOR (ID_VENDOR)
    ) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .state   (state),
        .path    (path),
        .tdi     (tdi),
        .bnd_in  (bnd_in),
        .bnd_upd (bnd_upd),
        .byp_q   (byp_q),
        .dr_out  (dr_out)
    );

    // tdo and its enable, driven on the falling edge in the shift states.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            case (state)
                ST_SH_IR: begin tdo <= ir_sr[0]; tdo_oe <= 1'b1; end
                ST_SH_DR: begin tdo <= dr_out;   tdo_oe <= 1'b1; end
                default:  begin tdo <= 1'b0;     tdo_oe <= 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/scan_tap_chk.sv
// Property checker for scan_tap, attached by bind.
module scan_tap_chk
    import scan_tap_pkg::*;
#(
    parameter int BSR_LEN = 16
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  tap_state_t         state,
    input  instr_t             ir_q,
    input  logic [1:0]         ir_low,
    input  dr_path_t           path,
    input  logic               byp_q,
    input  logic               tdo_oe,
    input  logic               force_hiz,
    input  logic [BSR_LEN-1:0] bnd_upd
);

    logic [2:0] ones;

    // Count consecutive rising edges with tms high, saturating at five.
    always_ff @(posedge tck) begin
        if (!rst_n || !tms)  ones <= 3'd0;
        else if (ones != 3'd5) ones <= ones + 3'd1;
    end

    p_five_ones_reset_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (ones == 3'd5) |-> (state == ST_RESET));

    p_ir_capture_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (ir_low == 2'b01));

    p_bypass_zero_r5: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && path == PATH_BYPASS) |=> !byp_q);

    p_hiz_rise_r6: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(force_hiz) |-> (state == ST_UPD_IR));

    p_upd_hold_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_DR) |-> $stable(bnd_upd));

    p_ir_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (state != ST_UPD_IR && state != ST_RESET) |-> $stable(ir_q));

    p_oe_shift_only_r10: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .tms       (tms),
    .state     (state),
    .ir_q      (ir_q),
    .ir_low    (ir_sr[1:0]),
    .path      (path),
    .byp_q     (byp_q),
    .tdo_oe    (tdo_oe),
    .force_hiz (force_hiz),
    .bnd_upd   (bnd_upd)
);

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;

    localparam int          N      = 16;
    localparam logic [31:0] ID_EXP = {3'h0, 17'h0B5C3, 11'b00000110100, 1'b1};

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [N-1:0] bnd_in = '0;
    logic         tdo, tdo_oe, force_hiz;
    logic [N-1:0] bnd_upd;

    int   checks = 0;
    int   failures = 0;
    logic last_oe;
    logic oe_ok;
    logic [N-1:0] upd_at_exit;
    logic hiz_at_exit;

    always #2.5 tck = ~tck;

    scan_tap u_scan_tap (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_oe(tdo_oe), .force_hiz(force_hiz), .bnd_in(bnd_in), .bnd_upd(bnd_upd)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One controller step: sample outputs after the falling edge, drive inputs.
    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o = tdo; last_oe = tdo_oe;
        tms = m; tdi = d;
        @(posedge tck);
    endtask

    // From Run-Test/Idle: load an instruction, return the captured bits.
    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], o);
            cap[i] = o;
        end
        @(negedge tck); #1; hiz_at_exit = force_hiz; tms = 1; @(posedge tck);
        step(0, 0, o);
    endtask

    // From Run-Test/Idle: full data scan of n bits, back to Idle.
    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0; oe_ok = 1'b1;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
            oe_ok = oe_ok & last_oe;
        end
        @(negedge tck); #1; upd_at_exit = bnd_upd; tms = 1; @(posedge tck);
        step(0, 0, o);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        logic o;
        chk("R1 oe in reset", 64'(tdo_oe), 64'd0);
        chk("R1 hiz in reset", 64'(force_hiz), 64'd0);
        chk("R1 bnd_upd in reset", 64'(bnd_upd), 64'd0);
        @(negedge tck); #1; rst_n = 1; tms = 0; @(posedge tck);
        step(0, 0, o);
        chk("R10 oe in idle", 64'(last_oe), 64'd0);
        scan_dr(32, 64'hFFFF_FFFF, d);
        chk("R1 R3 id word after reset", d[31:0], 64'(ID_EXP));
        chk("R10 oe during shift", 64'(oe_ok), 64'd1);
    endtask

    task automatic t_bypass;
        logic [2:0] cap;
        logic [63:0] d;
        logic [2:0] codes [4] = '{3'b111, 3'b011, 3'b101, 3'b110};
        foreach (codes[k]) begin
            load_ir(codes[k], cap);
            chk("R4 ir capture", 64'(cap), 64'd1);
            scan_dr(8, 64'hA5, d);
            chk("R5 bypass delay", d[7:0], {55'd0, 8'hA5, 1'b0} & 64'hFF);
            chk("R8 no update on bypass", 64'(bnd_upd), 64'd0);
        end
    endtask

    task automatic t_samplez;
        logic [2:0] cap;
        logic [63:0] d;
        bnd_in = 16'h3C5A;
        load_ir(3'b010, cap);
        chk("R6 hiz after update", 64'(force_hiz), 64'd1);
        scan_dr(N, 64'h9E61, d);
        chk("R7 capture under samplez", d[N-1:0], 64'h3C5A);
        chk("R8 hold at exit1", 64'(upd_at_exit), 64'd0);
        chk("R8 update value", 64'(bnd_upd), 64'h9E61);
        load_ir(3'b001, cap);
        chk("R9 hiz kept while shifting ir", 64'(hiz_at_exit), 64'd1);
        chk("R6 hiz off after new ir", 64'(force_hiz), 64'd0);
        scan_dr(32, 64'd0, d);
        chk("R3 id word", d[31:0], 64'(ID_EXP));
        chk("R8 no update on id scan", 64'(bnd_upd), 64'h9E61);
    endtask

    task automatic t_preload_extest;
        logic [2:0] cap;
        logic [63:0] d;
        bnd_in = 16'h0FF1;
        load_ir(3'b100, cap);
        chk("R6 hiz low under sample", 64'(force_hiz), 64'd0);
        scan_dr(N, 64'h1234, d);
        chk("R7 sample capture", d[N-1:0], 64'h0FF1);
        chk("R8 old value at exit1", 64'(upd_at_exit), 64'h9E61);
        chk("R8 preload update", 64'(bnd_upd), 64'h1234);
        bnd_in = 16'hC003;
        load_ir(3'b000, cap);
        scan_dr(N, 64'h8001, d);
        chk("R7 extest capture", d[N-1:0], 64'hC003);
        chk("R8 extest update", 64'(bnd_upd), 64'h8001);
    endtask

    task automatic t_escape;
        logic [2:0] cap;
        logic [63:0] d;
        logic o;
        bnd_in = 16'hB6D9;
        load_ir(3'b010, cap);
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 4; i++) step(0, 1, o);
        for (int i = 0; i < 5; i++) step(1, 1, o);
        step(0, 0, o);
        chk("R2 update on escape path", 64'(bnd_upd), {48'd0, 5'b11111, 11'(16'hB6D9 >> 5)});
        chk("R2 hiz cleared by reset state", 64'(force_hiz), 64'd0);
        scan_dr(32, 64'd0, d);
        chk("R2 id after five ones", d[31:0], 64'(ID_EXP));
    endtask

    initial begin
        repeat (4) @(posedge tck);
        t_reset();
        t_bypass();
        t_samplez();
        t_preload_extest();
        t_escape();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule